// File: doc/BRIEF.md
# Latched Input Conditioner with Acquisition Busy Trigger

This block takes a bus of asynchronous front-panel logic inputs, optionally flips each one, brings them into the system clock domain through a two-stage synchroniser, and derives a one-clock pulse from every rising edge. Each rising edge sets a sticky latch bit. Software reads the live levels and the latch bits through one register word, and clears chosen latch bits by writing a mask to the same register.

One input, the trigger input (bit 1 by default), drives a data-acquisition handshake. Its rising edge sets its latch bit, increments a trigger counter and captures the current timestamp. While that latch bit is set, the busy output is asserted. Software can also hold busy high through a bit in a software output register, so that busy can be forced at the end of a run and released at the start of the next one. A command write clears all latches and the trigger counter in a single operation.

The register port is a simple synchronous write strobe with a 3-bit address. Read data is registered, so it shows the addressed register one clock after the address is presented.

Top module: `trig_input_unit`

## Requirements
- R1: A read of address 0 returns the synchronised input levels in bits 15..0 and the latch bits in bits 31..16.
- R2: When a synchronised input goes from 0 to 1, its latch bit is set. The bit stays set after the input returns to 0, until it is cleared.
- R3: A write to address 0 clears each latch bit whose position holds a 1 in data bits 15..0. All other latch bits are unchanged.
- R4: If a rising edge and a clearing write hit the same latch bit in the same cycle, the bit ends up set.
- R5: Address 1 holds a per-input inversion mask. A 1 in a bit inverts that raw input before synchronisation, so it affects the level readback, the pulses and the latch setting.
- R6: `in_level_o` follows the (possibly inverted) input two clocks after it changes. `in_pulse_o` is high for exactly one clock, one clock after the level rises.
- R7: Each rising edge on the trigger input adds one to the 32-bit trigger counter read at address 3. The counter wraps modulo 2^32.
- R8: Each rising edge on the trigger input copies `ts_i` into the trigger timestamp read at address 4. The value is held until the next trigger.
- R9: `busy_o` is the trigger latch bit ORed with bit 1 of the software output register (address 2, read/write).
- R10: A write to address 5 with data bit 0 set clears all latch bits and the trigger counter. A write to address 5 with bit 0 clear has no effect.
- R11: After reset, all latches, the counter, the captured timestamp, the inversion mask, the software register and `busy_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in_i | input | 16 | Asynchronous input bus |
| ts_i | input | 32 | Running timestamp to capture on trigger |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data for the addressed register |
| in_level_o | output | 16 | Synchronised input levels |
| in_pulse_o | output | 16 | One-clock rising-edge pulses |
| busy_o | output | 1 | Acquisition busy |

## Verification
Single-bit rises are used to time the synchroniser and pulse outputs against the stated latency. Multi-bit patterns spread over non-adjacent positions expose swapped or shifted bit lanes in the readback and in the clear mask. A clear that arrives in the same cycle as an edge separates set-priority from clear-priority latches. Inversion is exercised both with the raw input idle and with it active, so inverting before the synchroniser can be told apart from inverting only on readback. Trigger pulses are given at two distinct timestamp values and followed by a timestamp change without a trigger, which separates edge capture from continuous tracking. Busy is driven separately from the latch and from the software bit.

// File: rtl/tiu_pkg.sv
package tiu_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STATUS = 3'd0,
    ADR_INVERT = 3'd1,
    ADR_SWOUT  = 3'd2,
    ADR_TCOUNT = 3'd3,
    ADR_TSTAMP = 3'd4,
    ADR_CMD    = 3'd5
  } tiu_addr_e;

  localparam int CMD_CLEAR_BIT = 0;
endpackage

// File: rtl/tiu_cond.sv
// Per-bit inversion, two-flop synchroniser and edge detector.
module tiu_cond #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] inv_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] edge_o,
  output logic [N-1:0] pulse_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, sync_q, prev_q, pulse_q;
    logic flipped;
    assign flipped = raw_i[i] ^ inv_i[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q  <= 1'b0;
        sync_q  <= 1'b0;
        prev_q  <= 1'b0;
        pulse_q <= 1'b0;
      end else begin
        meta_q  <= flipped;
        sync_q  <= meta_q;
        prev_q  <= sync_q;
        pulse_q <= sync_q & ~prev_q;
      end
    end

    assign level_o[i] = sync_q;
    assign edge_o[i]  = sync_q & ~prev_q;
    assign pulse_o[i] = pulse_q;
  end
endmodule

// File: rtl/tiu_latch.sv
// Sticky latch bank; a set in the same cycle as a clear wins.
module tiu_latch #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] latch_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= set_i[i] | (q & ~clr_i[i]);
    end
    assign latch_o[i] = q;
  end
endmodule

// File: rtl/tiu_trig.sv
// Trigger counter and timestamp capture.
module tiu_trig #(
  parameter int CNT_W = 32,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             clr_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [TS_W-1:0]  ts_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [TS_W-1:0]  ts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ts_q  <= '0;
    end else begin
      if (clr_i)      cnt_q <= '0;
      else if (hit_i) cnt_q <= cnt_q + 1'b1;
      if (hit_i)      ts_q  <= ts_i;
    end
  end

  assign cnt_o = cnt_q;
  assign ts_o  = ts_q;
endmodule

// File: rtl/tiu_regs.sv
// Register decode, control registers and registered read mux.
module tiu_regs
  import tiu_pkg::*;
#(
  parameter int N        = 16,
  parameter int CNT_W    = 32,
  parameter int TS_W     = 32,
  parameter int TRIG_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      level_i,
  input  logic [N-1:0]      latch_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic [N-1:0]      inv_o,
  output logic [N-1:0]      clr_mask_o,
  output logic              cmd_clr_o,
  output logic              soft_busy_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HALF = DATA_W / 2;

  logic [N-1:0]      inv_q;
  logic [DATA_W-1:0] sw_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_next;
  logic              wr_stat, wr_inv, wr_sw, wr_cmd;

  always_comb begin
    wr_stat = wr_i && (addr_i == ADR_STATUS);
    wr_inv  = wr_i && (addr_i == ADR_INVERT);
    wr_sw   = wr_i && (addr_i == ADR_SWOUT);
    wr_cmd  = wr_i && (addr_i == ADR_CMD);
  end

  assign cmd_clr_o  = wr_cmd && wdata_i[CMD_CLEAR_BIT];
  assign clr_mask_o = ({N{wr_stat}} & wdata_i[N-1:0]) | {N{cmd_clr_o}};

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q <= '0;
      sw_q  <= '0;
    end else begin
      if (wr_inv) inv_q <= wdata_i[N-1:0];
      if (wr_sw)  sw_q  <= wdata_i;
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_i)
      ADR_STATUS: begin
        rd_next[N-1:0]         = level_i;
        rd_next[HALF+N-1:HALF] = latch_i;
      end
      ADR_INVERT: rd_next[N-1:0]     = inv_q;
      ADR_SWOUT:  rd_next            = sw_q;
      ADR_TCOUNT: rd_next[CNT_W-1:0] = cnt_i;
      ADR_TSTAMP: rd_next[TS_W-1:0]  = ts_i;
      default:    rd_next            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign inv_o       = inv_q;
  assign soft_busy_o = sw_q[TRIG_BIT];
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/trig_input_unit.sv
module trig_input_unit
  import tiu_pkg::*;
#(
  parameter int N        = 16,
  parameter int CNT_W    = 32,
  parameter int TS_W     = 32,
  parameter int TRIG_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      raw_in_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N-1:0]      in_level_o,
  output logic [N-1:0]      in_pulse_o,
  output logic              busy_o
);
  logic [N-1:0]     inv_w, edge_w, latch_w, clr_w;
  logic [CNT_W-1:0] tcnt_w;
  logic [TS_W-1:0]  tts_w;
  logic             cmd_clr_w, soft_busy_w;
  logic             busy_q;

  tiu_cond #(.N(N)) u_cond (
    .clk(clk), .rst(rst), .raw_i(raw_in_i), .inv_i(inv_w),
    .level_o(in_level_o), .edge_o(edge_w), .pulse_o(in_pulse_o)
  );

  tiu_latch #(.N(N)) u_latch (
    .clk(clk), .rst(rst), .set_i(edge_w), .clr_i(clr_w), .latch_o(latch_w)
  );

  tiu_trig #(.CNT_W(CNT_W), .TS_W(TS_W)) u_trig (
    .clk(clk), .rst(rst), .hit_i(edge_w[TRIG_BIT]), .clr_i(cmd_clr_w),
    .ts_i(ts_i), .cnt_o(tcnt_w), .ts_o(tts_w)
  );

  tiu_regs #(.N(N), .CNT_W(CNT_W), .TS_W(TS_W), .TRIG_BIT(TRIG_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .level_i(in_level_o), .latch_i(latch_w),
    .cnt_i(tcnt_w), .ts_i(tts_w), .inv_o(inv_w), .clr_mask_o(clr_w),
    .cmd_clr_o(cmd_clr_w), .soft_busy_o(soft_busy_w), .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= latch_w[TRIG_BIT] | soft_busy_w;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/tiu_checker.sv
module tiu_checker
  import tiu_pkg::*;
#(
  parameter int N        = 16,
  parameter int CNT_W    = 32,
  parameter int TS_W     = 32,
  parameter int TRIG_BIT = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      edge_v,
  input logic [N-1:0]      latch,
  input logic [N-1:0]      pulse,
  input logic              busy,
  input logic              soft_busy,
  input logic [CNT_W-1:0]  cnt,
  input logic [TS_W-1:0]   ts_cap,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [N-1:0]      clr_data,
  input logic              cmd_bit
);
  logic         cmd_clr;
  logic [N-1:0] clr_mask;
  assign cmd_clr  = wr && (addr == ADR_CMD) && cmd_bit;
  assign clr_mask = ((wr && (addr == ADR_STATUS)) ? clr_data : '0) | {N{cmd_clr}};

  assert_latch_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(latch) & ~$past(clr_mask)) & ~latch) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (|edge_v) |=> ((latch & $past(edge_v)) == $past(edge_v)));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |=> ((pulse & $past(pulse)) == '0));

  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
    (edge_v[TRIG_BIT] && !cmd_clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_ts_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !edge_v[TRIG_BIT] |=> $stable(ts_cap));

  assert_busy_or_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (busy == ($past(latch[TRIG_BIT]) | $past(soft_busy))));

  assert_cmd_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_clr && (edge_v == '0)) |=> (latch == '0 && cnt == '0));
endmodule

bind trig_input_unit tiu_checker #(
  .N(N), .CNT_W(CNT_W), .TS_W(TS_W), .TRIG_BIT(TRIG_BIT)
) u_chk (
  .clk(clk), .rst(rst), .edge_v(edge_w), .latch(latch_w), .pulse(in_pulse_o),
  .busy(busy_o), .soft_busy(soft_busy_w), .cnt(tcnt_w), .ts_cap(tts_w),
  .wr(reg_wr_i), .addr(reg_addr_i), .clr_data(reg_wdata_i[N-1:0]),
  .cmd_bit(reg_wdata_i[0])
);

// File: tb/trig_input_unit_tb.sv
module trig_input_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] raw = '0;
  logic [31:0] ts = '0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] level, pulse;
  logic        busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_input_unit u_dut (
    .clk(clk), .rst(rst), .raw_in_i(raw), .ts_i(ts), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .in_level_o(level), .in_pulse_o(pulse), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // called at a negedge; write sampled at the following posedge
  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(3'd0, d); chk("R11 status", d, 32'h0);
    reg_read(3'd3, d); chk("R11 count", d, 32'h0);
    reg_read(3'd4, d); chk("R11 tstamp", d, 32'h0);
    reg_read(3'd1, d); chk("R11 invert", d, 32'h0);
    chk("R11 busy", {31'b0, busy}, 32'h0);
  endtask

  task automatic t_pulse();
    raw = 16'h0020;               // n0
    @(negedge clk);               // n1
    chk("R6 level early", {16'b0, level}, 32'h0);
    @(negedge clk);               // n2
    chk("R6 level", {16'b0, level}, 32'h0020);
    chk("R6 pulse early", {16'b0, pulse}, 32'h0);
    @(negedge clk);               // n3
    chk("R6 pulse", {16'b0, pulse}, 32'h0020);
    @(negedge clk);               // n4
    chk("R6 pulse width", {16'b0, pulse}, 32'h0);
    raw = '0;
    idle(4);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    reg_read(3'd0, d);
    chk("R2 sticky bit5", d, 32'h0020_0000);
    raw = 16'h9400;
    idle(4);
    reg_read(3'd0, d);
    chk("R1 level+latch", d, 32'h9420_9400);
    raw = '0;
    idle(4);
    reg_read(3'd0, d);
    chk("R2 held after fall", d, 32'h9420_0000);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    reg_write(3'd0, 32'hFFFF_1000);
    reg_read(3'd0, d);
    chk("R3 clear bit12 only", d, 32'h8420_0000);
    reg_write(3'd0, 32'h0000_FFFF);
    reg_read(3'd0, d);
    chk("R3 clear all", d, 32'h0);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    raw = 16'h0008;        // n0
    @(negedge clk);        // n1
    @(negedge clk);        // n2: edge seen at next posedge
    reg_write(3'd0, 32'h0000_0008);
    reg_read(3'd0, d);
    chk("R4 set beats clear", d, 32'h0008_0008);
    raw = '0;
    idle(4);
    reg_write(3'd0, 32'h0000_FFFF);
  endtask

  task automatic t_invert();
    logic [31:0] d;
    reg_write(3'd1, 32'h0000_0004);
    idle(4);
    reg_read(3'd0, d);
    chk("R5 inverted idle input", d, 32'h0004_0004);
    reg_read(3'd1, d);
    chk("R5 invert readback", d, 32'h0000_0004);
    reg_write(3'd0, 32'h0000_0004);
    raw = 16'h0004;
    idle(4);
    reg_read(3'd0, d);
    chk("R5 inverted active input", d, 32'h0);
    raw = 16'h0000;
    idle(4);
    reg_read(3'd0, d);
    chk("R5 raw fall sets latch", d, 32'h0004_0004);
    reg_write(3'd1, 32'h0);
    idle(4);
    reg_write(3'd0, 32'h0000_FFFF);
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    ts = 32'h1234_5678;
    raw = 16'h0002;
    idle(3);
    raw = '0;
    idle(3);
    chk("R9 busy from latch", {31'b0, busy}, 32'h1);
    reg_read(3'd3, d); chk("R7 count one", d, 32'h1);
    reg_read(3'd4, d); chk("R8 tstamp first", d, 32'h1234_5678);
    ts = 32'h0BAD_0001;
    raw = 16'h0002;
    idle(3);
    raw = '0;
    idle(3);
    reg_read(3'd3, d); chk("R7 count two", d, 32'h2);
    reg_read(3'd4, d); chk("R8 tstamp second", d, 32'h0BAD_0001);
    ts = 32'hFFFF_0000;
    idle(3);
    reg_read(3'd4, d); chk("R8 tstamp holds", d, 32'h0BAD_0001);
    reg_write(3'd0, 32'h0000_0002);
    idle(2);
    chk("R9 busy released", {31'b0, busy}, 32'h0);
    reg_write(3'd2, 32'h0000_0002);
    idle(2);
    chk("R9 soft busy", {31'b0, busy}, 32'h1);
    reg_read(3'd2, d); chk("R9 swout readback", d, 32'h0000_0002);
    reg_write(3'd2, 32'h0);
    idle(2);
    chk("R9 soft busy off", {31'b0, busy}, 32'h0);
  endtask

  task automatic t_command();
    logic [31:0] d;
    raw = 16'h0402;
    idle(3);
    raw = '0;
    idle(3);
    reg_write(3'd5, 32'h0000_0000);
    reg_read(3'd3, d); chk("R10 no-op keeps count", d, 32'h3);
    reg_read(3'd0, d); chk("R10 no-op keeps latch", d, 32'h0402_0000);
    reg_write(3'd5, 32'h0000_0001);
    reg_read(3'd3, d); chk("R10 count cleared", d, 32'h0);
    reg_read(3'd0, d); chk("R10 latches cleared", d, 32'h0);
    idle(1);
    chk("R10 busy dropped", {31'b0, busy}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pulse();
    t_latch();
    t_clear();
    t_setwins();
    t_invert();
    t_trigger();
    t_command();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule